// File: doc/BRIEF.md
# Out-of-Order Reservation Station with Three-Wide Select

This block buffers instructions that have been renamed and are waiting for their source operands. It sits in a tag-based out-of-order core. Each cycle up to three instructions arrive on a dispatch port. Each instruction carries an opcode payload, a destination reorder-buffer tag, and two operands. An operand is either a value that is already known (tag zero) or the tag of the instruction that will produce it. Each arriving instruction is placed in a free entry of a sixteen-entry pool.

A result bus carries one producer tag and its value per cycle. Every waiting operand that names that tag takes the value and becomes available. An entry is ready once both of its operands are available. From the ready entries, a fixed-priority selector grants up to three issue lanes per cycle. The lowest-indexed entries win. A granted entry leaves the pool at once. A downstream hold freezes issue, and a flush empties the pool.

Top module: `rs_station`

## Requirements
- R1: During reset and on the first cycle after it, no entry is held: `iss_valid` is 0, and a full three-slot dispatch is accepted without any stall.
- R2: Dispatch slots are ranked by index among the valid slots. Slot s is stalled (`disp_stall[s]`=1) exactly when it is valid and its rank (0-based count of valid slots below it) is not less than the number of free entries at the start of the cycle. A stalled slot is not written, and an invalid slot never stalls.
- R3: Operand tag 0 means the operand is available. An entry becomes a candidate for issue only while both of its operand tags are 0.
- R4: When `bcast_valid` is high, every held operand whose nonzero tag equals `bcast_tag` takes `bcast_val` and clears its tag. The entry can issue from the next cycle, carrying the captured value. A broadcast of any other tag leaves the operand waiting.
- R5: A broadcast in the same cycle as a dispatch is applied to the arriving operands. A matching arriving operand is stored as available with the broadcast value.
- R6: At most three grants are made per cycle. Issue lane k (fields at bit offset k times the field width) carries the (k+1)-th lowest-indexed ready entry. The lanes fill from lane 0 upward, so `iss_valid` is always of the form 000, 001, 011 or 111.
- R7: Accepted dispatch slots are written, in slot order, to the lowest-indexed free entries. A hole left by an earlier issue is therefore filled before any higher entry.
- R8: A granted entry is released in the cycle of its grant. Dispatch sees it as free from the next cycle on, not in the grant cycle.
- R9: While `iss_hold` is high, `iss_valid` is 0 and no entry is released. Held entries issue after the hold drops. Dispatch and wakeup keep working during the hold.
- R10: `flush` empties every entry at the next edge. Instructions dispatched in the flush cycle are dropped, and no grant is made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Empty the pool, drop this cycle's dispatch |
| disp_valid | input | WIDTH | Per-slot dispatch request |
| disp_op | input | WIDTH*OP_W | Per-slot opcode payload |
| disp_dest | input | WIDTH*TAG_W | Per-slot destination tag |
| disp_src1_tag | input | WIDTH*TAG_W | Per-slot first operand tag (0 = available) |
| disp_src1_val | input | WIDTH*DATA_W | Per-slot first operand value |
| disp_src2_tag | input | WIDTH*TAG_W | Per-slot second operand tag (0 = available) |
| disp_src2_val | input | WIDTH*DATA_W | Per-slot second operand value |
| disp_stall | output | WIDTH | Per-slot refusal for lack of a free entry |
| bcast_valid | input | 1 | Result bus carries a result |
| bcast_tag | input | TAG_W | Producer tag on the result bus |
| bcast_val | input | DATA_W | Value on the result bus |
| iss_hold | input | 1 | Downstream hold: no grants, no releases |
| iss_valid | output | WIDTH | Per-lane issue grant |
| iss_op | output | WIDTH*OP_W | Per-lane opcode payload |
| iss_dest | output | WIDTH*TAG_W | Per-lane destination tag |
| iss_src1_val | output | WIDTH*DATA_W | Per-lane first operand value |
| iss_src2_val | output | WIDTH*DATA_W | Per-lane second operand value |

## Verification
Faults inside the station show up at the ports within a cycle or two. A missed or wrong wakeup appears as an entry that never issues or that issues with the wrong value on its lane. A faulty allocation or release appears in the order of grants one cycle after the entries become ready, or as a wrong `disp_stall` in the cycle after a grant. The occupancy count is tied to dispatch acceptances and grants on every edge. A lost or duplicated entry is therefore flagged on the very edge where it goes wrong. The bench sweeps every fill level against every dispatch pattern, and drains several wakeup masks to confirm the grant order.

// File: rtl/rs_pkg.sv
package rs_pkg;
  localparam int RS_DEF_ENTRIES = 16;
  localparam int RS_DEF_WIDTH   = 3;
  localparam int RS_DEF_OP_W    = 8;
  localparam int RS_DEF_TAG_W   = 5;
  localparam int RS_DEF_DATA_W  = 32;

  // Operand condition as seen by the wakeup logic.
  typedef enum logic {
    OPD_AVAILABLE = 1'b0,
    OPD_WAITING   = 1'b1
  } rs_opd_state_e;
endpackage

// File: rtl/rs_pick.sv
// Picks the K lowest-indexed set bits of req, one one-hot row per pick.
module rs_pick #(
  parameter int N = 16,
  parameter int K = 3
) (
  input  logic [N-1:0]        req,
  output logic [K-1:0][N-1:0] grant
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [K:0][N-1:0] remain;

  assign remain[0] = req;

  for (genvar k = 0; k < K; k++) begin : g_peel
    assign grant[k]      = remain[k] & (~remain[k] + ONE);
    assign remain[k + 1] = remain[k] & ~grant[k];
  end
endmodule

// File: rtl/rs_operand.sv
// One source operand: tag plus value, with wakeup capture.
module rs_operand
  import rs_pkg::*;
#(
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              live,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [DATA_W-1:0] ld_val,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic [DATA_W-1:0] val_q,
  output rs_opd_state_e     state
);
  logic [TAG_W-1:0] tag_q;
  logic             hit;

  assign state = (tag_q != '0) ? OPD_WAITING : OPD_AVAILABLE;
  assign hit   = live && bc_valid && (state == OPD_WAITING) && (bc_tag == tag_q);

  always_ff @(posedge clk) begin
    if (rst)       tag_q <= '0;
    else if (load) tag_q <= ld_tag;
    else if (hit)  tag_q <= '0;
  end

  // Value storage carries no reset; the tag and the occupancy bit qualify it.
  always_ff @(posedge clk) begin
    if (load)     val_q <= ld_val;
    else if (hit) val_q <= bc_val;
  end
endmodule

// File: rtl/rs_slot.sv
// One station entry: occupancy, payload and two operands.
module rs_slot
  import rs_pkg::*;
#(
  parameter int OP_W   = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [OP_W-1:0]   wr_op,
  input  logic [TAG_W-1:0]  wr_dest,
  input  logic [TAG_W-1:0]  wr_t1,
  input  logic [DATA_W-1:0] wr_v1,
  input  logic [TAG_W-1:0]  wr_t2,
  input  logic [DATA_W-1:0] wr_v2,
  input  logic              rel,
  input  logic              bc_valid,
  input  logic [TAG_W-1:0]  bc_tag,
  input  logic [DATA_W-1:0] bc_val,
  output logic              occ,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [TAG_W-1:0]  dest,
  output logic [DATA_W-1:0] v1,
  output logic [DATA_W-1:0] v2
);
  rs_opd_state_e st1, st2;

  always_ff @(posedge clk) begin
    if (rst || clr)  occ <= 1'b0;
    else if (wr_en)  occ <= 1'b1;
    else if (rel)    occ <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      op   <= wr_op;
      dest <= wr_dest;
    end
  end

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src1 (
    .clk(clk), .rst(rst), .load(wr_en), .live(occ),
    .ld_tag(wr_t1), .ld_val(wr_v1),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .val_q(v1), .state(st1)
  );

  rs_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_src2 (
    .clk(clk), .rst(rst), .load(wr_en), .live(occ),
    .ld_tag(wr_t2), .ld_val(wr_v2),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_val(bc_val),
    .val_q(v2), .state(st2)
  );

  assign ready = occ && (st1 == OPD_AVAILABLE) && (st2 == OPD_AVAILABLE);
endmodule

// File: rtl/rs_station.sv
module rs_station
  import rs_pkg::*;
#(
  parameter int N_ENT  = RS_DEF_ENTRIES,
  parameter int WIDTH  = RS_DEF_WIDTH,
  parameter int OP_W   = RS_DEF_OP_W,
  parameter int TAG_W  = RS_DEF_TAG_W,
  parameter int DATA_W = RS_DEF_DATA_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    flush,
  input  logic [WIDTH-1:0]        disp_valid,
  input  logic [WIDTH*OP_W-1:0]   disp_op,
  input  logic [WIDTH*TAG_W-1:0]  disp_dest,
  input  logic [WIDTH*TAG_W-1:0]  disp_src1_tag,
  input  logic [WIDTH*DATA_W-1:0] disp_src1_val,
  input  logic [WIDTH*TAG_W-1:0]  disp_src2_tag,
  input  logic [WIDTH*DATA_W-1:0] disp_src2_val,
  output logic [WIDTH-1:0]        disp_stall,
  input  logic                    bcast_valid,
  input  logic [TAG_W-1:0]        bcast_tag,
  input  logic [DATA_W-1:0]       bcast_val,
  input  logic                    iss_hold,
  output logic [WIDTH-1:0]        iss_valid,
  output logic [WIDTH*OP_W-1:0]   iss_op,
  output logic [WIDTH*TAG_W-1:0]  iss_dest,
  output logic [WIDTH*DATA_W-1:0] iss_src1_val,
  output logic [WIDTH*DATA_W-1:0] iss_src2_val
);
  localparam int RANK_W = $clog2(WIDTH + 1);

  // Per-entry state seen from outside the slots.
  logic [N_ENT-1:0] occ_vec, rdy_vec, wr_en_vec, rel_vec, iss_req;
  logic [OP_W-1:0]   e_op   [N_ENT];
  logic [TAG_W-1:0]  e_dest [N_ENT];
  logic [DATA_W-1:0] e_v1   [N_ENT];
  logic [DATA_W-1:0] e_v2   [N_ENT];

  // Per-entry write data.
  logic [OP_W-1:0]   w_op   [N_ENT];
  logic [TAG_W-1:0]  w_dest [N_ENT];
  logic [TAG_W-1:0]  w_t1   [N_ENT];
  logic [DATA_W-1:0] w_v1   [N_ENT];
  logic [TAG_W-1:0]  w_t2   [N_ENT];
  logic [DATA_W-1:0] w_v2   [N_ENT];

  // Per-slot operands after same-cycle forwarding.
  logic [TAG_W-1:0]  f_t1 [WIDTH];
  logic [DATA_W-1:0] f_v1 [WIDTH];
  logic [TAG_W-1:0]  f_t2 [WIDTH];
  logic [DATA_W-1:0] f_v2 [WIDTH];

  logic [WIDTH-1:0][N_ENT-1:0] free_pick, iss_pick;
  logic [WIDTH-1:0][N_ENT-1:0] slot_row;
  logic [WIDTH-1:0]            slot_take;

  // ---------------- dispatch side ----------------
  for (genvar s = 0; s < WIDTH; s++) begin : g_fwd
    logic [TAG_W-1:0] t1_in, t2_in;
    logic             m1, m2;
    assign t1_in = disp_src1_tag[s*TAG_W +: TAG_W];
    assign t2_in = disp_src2_tag[s*TAG_W +: TAG_W];
    assign m1    = bcast_valid && (t1_in != '0) && (t1_in == bcast_tag);
    assign m2    = bcast_valid && (t2_in != '0) && (t2_in == bcast_tag);
    assign f_t1[s] = m1 ? '0 : t1_in;
    assign f_v1[s] = m1 ? bcast_val : disp_src1_val[s*DATA_W +: DATA_W];
    assign f_t2[s] = m2 ? '0 : t2_in;
    assign f_v2[s] = m2 ? bcast_val : disp_src2_val[s*DATA_W +: DATA_W];
  end

  rs_pick #(.N(N_ENT), .K(WIDTH)) u_free_pick (
    .req(~occ_vec),
    .grant(free_pick)
  );

  // Valid slots are ranked in order; the rank picks the free-entry row.
  always_comb begin
    logic [RANK_W-1:0] rank;
    rank      = '0;
    slot_take = '0;
    slot_row  = '0;
    for (int s = 0; s < WIDTH; s++) begin
      if (disp_valid[s]) begin
        if (free_pick[rank] != '0) begin
          slot_take[s] = 1'b1;
          slot_row[s]  = free_pick[rank];
        end
        rank = rank + 1'b1;
      end
    end
  end

  assign disp_stall = disp_valid & ~slot_take;

  always_comb begin
    for (int e = 0; e < N_ENT; e++) begin
      wr_en_vec[e] = 1'b0;
      w_op[e]      = '0;
      w_dest[e]    = '0;
      w_t1[e]      = '0;
      w_v1[e]      = '0;
      w_t2[e]      = '0;
      w_v2[e]      = '0;
      for (int s = 0; s < WIDTH; s++) begin
        if (slot_take[s] && slot_row[s][e]) begin
          wr_en_vec[e] = !flush;
          w_op[e]      = disp_op[s*OP_W +: OP_W];
          w_dest[e]    = disp_dest[s*TAG_W +: TAG_W];
          w_t1[e]      = f_t1[s];
          w_v1[e]      = f_v1[s];
          w_t2[e]      = f_t2[s];
          w_v2[e]      = f_v2[s];
        end
      end
    end
  end

  // ---------------- entry pool ----------------
  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    rs_slot #(.OP_W(OP_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
      .clk(clk), .rst(rst), .clr(flush),
      .wr_en(wr_en_vec[e]),
      .wr_op(w_op[e]), .wr_dest(w_dest[e]),
      .wr_t1(w_t1[e]), .wr_v1(w_v1[e]),
      .wr_t2(w_t2[e]), .wr_v2(w_v2[e]),
      .rel(rel_vec[e]),
      .bc_valid(bcast_valid), .bc_tag(bcast_tag), .bc_val(bcast_val),
      .occ(occ_vec[e]), .ready(rdy_vec[e]),
      .op(e_op[e]), .dest(e_dest[e]), .v1(e_v1[e]), .v2(e_v2[e])
    );
  end

  // ---------------- issue side ----------------
  assign iss_req = rdy_vec & {N_ENT{!iss_hold && !flush}};

  rs_pick #(.N(N_ENT), .K(WIDTH)) u_iss_pick (
    .req(iss_req),
    .grant(iss_pick)
  );

  always_comb begin
    rel_vec = '0;
    for (int k = 0; k < WIDTH; k++) rel_vec = rel_vec | iss_pick[k];
  end

  always_comb begin
    iss_valid    = '0;
    iss_op       = '0;
    iss_dest     = '0;
    iss_src1_val = '0;
    iss_src2_val = '0;
    for (int k = 0; k < WIDTH; k++) begin
      iss_valid[k] = |iss_pick[k];
      for (int e = 0; e < N_ENT; e++) begin
        if (iss_pick[k][e]) begin
          iss_op[k*OP_W +: OP_W]           = e_op[e];
          iss_dest[k*TAG_W +: TAG_W]       = e_dest[e];
          iss_src1_val[k*DATA_W +: DATA_W] = e_v1[e];
          iss_src2_val[k*DATA_W +: DATA_W] = e_v2[e];
        end
      end
    end
  end
endmodule

// File: rtl/rs_station_chk.sv
module rs_station_chk #(
  parameter int N_ENT = 16,
  parameter int WIDTH = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic             iss_hold,
  input logic [WIDTH-1:0] disp_valid,
  input logic [WIDTH-1:0] disp_stall,
  input logic [WIDTH-1:0] iss_valid,
  input logic [N_ENT-1:0] occ_vec
);
  logic [WIDTH-1:0] iv_inc;
  assign iv_inc = iss_valid + {{(WIDTH-1){1'b0}}, 1'b1};

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (occ_vec == '0 && iss_valid == '0));

  // R2
  stall_only_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (disp_stall & ~disp_valid) == '0);

  // R2
  occupancy_balance_chk: assert property (@(posedge clk) disable iff (rst)
    !flush |=> $countones(occ_vec) == $past($countones(occ_vec))
               + $past($countones(disp_valid & ~disp_stall))
               - $past($countones(iss_valid)));

  // R6
  lanes_prefix_chk: assert property (@(posedge clk) disable iff (rst)
    (iv_inc & iss_valid) == '0);

  // R6
  grants_within_pool_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(iss_valid) <= $countones(occ_vec));

  // R9
  hold_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
    iss_hold |-> iss_valid == '0);

  // R9
  hold_keeps_entries_chk: assert property (@(posedge clk) disable iff (rst)
    (iss_hold && !flush) |=> (occ_vec & $past(occ_vec)) == $past(occ_vec));

  // R10
  flush_empties_chk: assert property (@(posedge clk) disable iff (rst)
    flush |=> occ_vec == '0);
endmodule

bind rs_station rs_station_chk #(.N_ENT(N_ENT), .WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .flush(flush), .iss_hold(iss_hold),
  .disp_valid(disp_valid), .disp_stall(disp_stall),
  .iss_valid(iss_valid), .occ_vec(occ_vec)
);

// File: tb/tb_rs_station.sv
module tb_rs_station;
  localparam int N = 16, W = 3, OPW = 8, TW = 5, DW = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst, flush, bcast_valid, iss_hold;
  logic [W-1:0]    disp_valid, disp_stall, iss_valid;
  logic [W*OPW-1:0] disp_op, iss_op;
  logic [W*TW-1:0] disp_dest, disp_src1_tag, disp_src2_tag, iss_dest;
  logic [W*DW-1:0] disp_src1_val, disp_src2_val, iss_src1_val, iss_src2_val;
  logic [TW-1:0]   bcast_tag;
  logic [DW-1:0]   bcast_val;

  rs_station #(.N_ENT(N), .WIDTH(W), .OP_W(OPW), .TAG_W(TW), .DATA_W(DW)) dut (
    .clk(clk), .rst(rst), .flush(flush),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_dest(disp_dest),
    .disp_src1_tag(disp_src1_tag), .disp_src1_val(disp_src1_val),
    .disp_src2_tag(disp_src2_tag), .disp_src2_val(disp_src2_val),
    .disp_stall(disp_stall),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag), .bcast_val(bcast_val),
    .iss_hold(iss_hold), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_dest(iss_dest), .iss_src1_val(iss_src1_val), .iss_src2_val(iss_src2_val)
  );

  int n_vec = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    disp_valid = '0; disp_op = '0; disp_dest = '0;
    disp_src1_tag = '0; disp_src1_val = '0;
    disp_src2_tag = '0; disp_src2_val = '0;
    bcast_valid = 1'b0; bcast_tag = '0; bcast_val = '0;
    iss_hold = 1'b0; flush = 1'b0;
  endtask

  task automatic put(int s, int op, int t1, int v1, int t2, int v2);
    disp_valid[s] = 1'b1;
    disp_op[s*OPW +: OPW]       = OPW'(op);
    disp_dest[s*TW +: TW]       = TW'(op % 31 + 1);
    disp_src1_tag[s*TW +: TW]   = TW'(t1);
    disp_src1_val[s*DW +: DW]   = DW'(v1);
    disp_src2_tag[s*TW +: TW]   = TW'(t2);
    disp_src2_val[s*DW +: DW]   = DW'(v2);
  endtask

  task automatic bcast(int tag, int val);
    bcast_valid = 1'b1; bcast_tag = TW'(tag); bcast_val = DW'(val);
  endtask

  task automatic settle(); #1; endtask
  task automatic adv(); @(posedge clk); #2; idle(); endtask
  task automatic do_flush(); flush = 1'b1; adv(); endtask

  // Entry i gets op i; chain=1 gives it pending tag i+1, else tag 31.
  task automatic fill(int n, bit chain);
    for (int i = 0; i < n; i++) begin
      put(i % 3, i, chain ? i + 1 : 31, 0, 0, i * 5);
      if (i % 3 == 2 || i == n - 1) adv();
    end
  endtask

  function automatic logic [63:0] lop(int k);  return 64'(iss_op[k*OPW +: OPW]); endfunction
  function automatic logic [63:0] ldst(int k); return 64'(iss_dest[k*TW +: TW]); endfunction
  function automatic logic [63:0] lv1(int k);  return 64'(iss_src1_val[k*DW +: DW]); endfunction
  function automatic logic [63:0] lv2(int k);  return 64'(iss_src2_val[k*DW +: DW]); endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] masks [8];
    masks = '{16'hFFFF, 16'h0001, 16'h8000, 16'hA5A5,
              16'h1248, 16'h7000, 16'h0000, 16'h0F0F};
    idle();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    rst = 1'b0;

    // R1: empty after reset
    settle();
    chk("R1 iss_valid", 64'(iss_valid), 0);
    put(0, 1, 31, 0, 0, 0); put(1, 2, 31, 0, 0, 0); put(2, 3, 31, 0, 0, 0);
    settle();
    chk("R1 disp_stall", 64'(disp_stall), 0);
    adv();

    // R2 sweep: every fill level against every dispatch pattern, hold high (R9)
    for (int n = 0; n <= N; n++) begin
      for (int p = 1; p < 8; p++) begin
        logic [W-1:0] exp;
        int r, freec;
        do_flush();
        fill(n, 1'b0);
        for (int s = 0; s < W; s++) if (p[s]) put(s, 100 + s, 31, 0, 0, 0);
        iss_hold = 1'b1;
        freec = N - n; r = 0; exp = '0;
        for (int s = 0; s < W; s++) begin
          if (p[s]) begin
            if (r >= freec) exp[s] = 1'b1;
            r++;
          end
        end
        settle();
        chk("R2 stall pattern", 64'(disp_stall), 64'(exp));
        adv();
      end
    end

    // R6/R7/R4/R9: wake a mask under hold, then drain in index order
    for (int m = 0; m < 8; m++) begin
      int lst [16];
      int cnt, pos;
      do_flush();
      fill(N, 1'b1);
      cnt = 0;
      for (int i = 0; i < N; i++) begin
        if (masks[m][i]) begin
          lst[cnt] = i; cnt++;
          bcast(i + 1, 32'h1000 + i * 3);
          iss_hold = 1'b1;
          settle();
          chk("R9 no grant under hold", 64'(iss_valid), 0);
          adv();
        end
      end
      pos = 0;
      while (pos < cnt) begin
        logic [W-1:0] ev;
        ev = '0;
        settle();
        for (int k = 0; k < W; k++) if (pos + k < cnt) ev[k] = 1'b1;
        chk("R6 lane fill", 64'(iss_valid), 64'(ev));
        for (int k = 0; k < W; k++) begin
          if (pos + k < cnt) begin
            chk("R6 grant order", lop(k), 64'(lst[pos + k]));
            chk("R7 dest payload", ldst(k), 64'(lst[pos + k] + 1));
            chk("R4 captured value", lv1(k), 64'(32'h1000 + lst[pos + k] * 3));
            chk("R4 kept value", lv2(k), 64'(lst[pos + k] * 5));
          end
        end
        adv();
        pos += W;
      end
      settle();
      chk("R3 waiting entries stay", 64'(iss_valid), 0);
    end

    // R3/R4: second operand waiting, non-matching broadcast, then match
    do_flush();
    put(0, 8'h55, 0, 11, 9, 0);
    adv();
    settle();
    chk("R3 one tag pending", 64'(iss_valid), 0);
    adv();
    bcast(8, 32'h1111);
    settle();
    adv();
    settle();
    chk("R4 other tag ignored", 64'(iss_valid), 0);
    bcast(9, 32'hBEEF);
    settle();
    chk("R4 capture not same cycle", 64'(iss_valid), 0);
    adv();
    settle();
    chk("R4 issues after capture", 64'(iss_valid), 1);
    chk("R4 captured src2", lv2(0), 64'h0000BEEF);
    chk("R3 src1 value", lv1(0), 11);
    adv();
    settle();
    chk("R8 released after grant", 64'(iss_valid), 0);

    // R5: forwarding into a dispatching operand
    do_flush();
    put(0, 8'h66, 7, 0, 0, 3);
    put(1, 8'h67, 12, 0, 0, 4);
    bcast(7, 32'hCAFE);
    adv();
    settle();
    chk("R5 forwarded entry issues", 64'(iss_valid), 1);
    chk("R5 forwarded op", lop(0), 64'h66);
    chk("R5 forwarded value", lv1(0), 64'hCAFE);
    adv();
    settle();
    chk("R5 unmatched stays", 64'(iss_valid), 0);

    // R8/R7: release timing and hole reuse
    do_flush();
    fill(N, 1'b1);
    bcast(6, 32'h60); iss_hold = 1'b1;
    adv();
    bcast(1, 32'h10); iss_hold = 1'b1;
    adv();
    put(0, 8'h30, 0, 0, 0, 0);
    settle();
    chk("R8 grants", 64'(iss_valid), 3);
    chk("R6 lane0 entry", lop(0), 0);
    chk("R6 lane1 entry", lop(1), 5);
    chk("R8 no same-cycle reuse", 64'(disp_stall), 1);
    adv();
    put(0, 8'h40, 0, 0, 0, 0); put(1, 8'h41, 0, 0, 0, 0); put(2, 8'h42, 0, 0, 0, 0);
    settle();
    chk("R8 reuse next cycle", 64'(disp_stall), 4);
    adv();
    settle();
    chk("R7 hole fill grants", 64'(iss_valid), 3);
    chk("R7 hole 0 first", lop(0), 64'h40);
    chk("R7 hole 5 second", lop(1), 64'h41);
    adv();

    // R10: dispatch in the flush cycle is dropped
    put(0, 1, 0, 0, 0, 0); put(1, 2, 0, 0, 0, 0); put(2, 3, 0, 0, 0, 0);
    flush = 1'b1;
    settle();
    chk("R10 no grant in flush cycle", 64'(iss_valid), 0);
    adv();
    settle();
    chk("R10 dispatch dropped", 64'(iss_valid), 0);
    adv();

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule